// File: doc/BRIEF.md
# Synchronous DMA Burst Strobe Timer

This block produces the host side of the timing for a synchronous, double-edge parallel disk burst. Software stores a cycle time, a ready-to-pause time and a base-clock choice for each drive. When a burst starts, the values for the addressed drive are captured. They stay fixed until that burst ends. All timing is counted in pulses of the chosen base-clock tick, not in cycles of the system clock.

On a write burst the block toggles its data strobe and places the next 16-bit word from the data FIFO on the bus at every edge, rising and falling alike. Two edges are never closer together than the cycle time. If the FIFO runs dry, the strobe holds its level and waits. On a read burst the device drives the strobe. The block captures one word on each incoming edge. When the host asks to end a read, the block waits for the ready handshake to drop, counts the ready-to-pause interval, and then raises STOP. When the host asks to end a write, the block lets the current pulse reach the cycle time and then raises STOP.

Top module: `udma_strobe_timer`

## Requirements
- R1: After reset, host_strobe, stop, fifo_pop and rd_valid are all 0.
- R2: A configuration write stores cycle time, ready-to-pause time and base select (value k selects base_tick[k]) for drive cfg_drive. A burst uses the values of start_drive, so drives with different settings give different strobe timing.
- R3: During a write burst (start_read=0), every toggle of host_strobe, in either direction, comes with the next FIFO word on host_data. The FIFO is popped (fifo_pop=1) in the cycle that decides the toggle.
- R4: With the FIFO never empty, consecutive strobe toggles are exactly ct ticks of the selected base apart. The first toggle comes ct ticks after the start cycle; ticks in the start cycle and in each toggle-deciding cycle do not count toward the next interval.
- R5: A stored cycle time or ready-to-pause time of 0 behaves exactly as 1.
- R6: While fifo_valid is 0 the strobe holds its level. After data returns, no interval is shorter than ct ticks.
- R7: A configuration write during a burst does not change that burst's timing.
- R8: During a read burst (start_read=1), each edge of dev_strobe yields rd_valid=1 one cycle later, with the dev_data present at that edge on rd_data. Edges outside a read burst produce no rd_valid.
- R9: In a read burst, after end_req, the first cycle in which peer_rdy is 0 begins the pause count. stop rises in the cycle after the one holding the rp-th tick of the selected base, counting that first cycle.
- R10: After end_req in a write burst, the strobe stops toggling. stop rises, and no further FIFO word is popped until the next burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_drive | input | DRV_W | Drive whose timing is written |
| cfg_ct | input | TIME_W | Cycle time in base ticks |
| cfg_rp | input | TIME_W | Ready-to-pause time in base ticks |
| cfg_base | input | BSEL_W | Base tick select |
| base_tick | input | N_BASE | Base clock tick enables |
| start | input | 1 | Begin a burst (accepted when idle) |
| start_drive | input | DRV_W | Drive addressed by the burst |
| start_read | input | 1 | 1 = read burst, 0 = write burst |
| end_req | input | 1 | Host asks to end the burst |
| peer_rdy | input | 1 | Ready handshake, high = ready |
| fifo_valid | input | 1 | Write FIFO has a word |
| fifo_data | input | DATA_W | Write FIFO head word |
| fifo_pop | output | 1 | Consume FIFO head this cycle |
| host_strobe | output | 1 | Write data strobe |
| host_data | output | DATA_W | Write data bus |
| stop | output | 1 | Burst termination signal |
| dev_strobe | input | 1 | Device-driven read strobe |
| dev_data | input | DATA_W | Read data bus |
| rd_valid | output | 1 | Read word captured |
| rd_data | output | DATA_W | Captured read word |

## Verification
A strobe toggle decided in one cycle shows on host_strobe in the next cycle. The monitor therefore counts selected base ticks from the cycle after a start or a toggle up to the cycle before the next toggle, and compares the count with ct exactly. A captured read word is due one cycle after the bench flips dev_strobe, so the scoreboard pops a word only when rd_valid is seen high. stop is due one cycle after the rp-th counted tick, with counting from the first cycle in which peer_rdy is low. Every sample is taken at the falling clock edge, and every input changes just after the rising edge.

// File: rtl/udma_pkg.sv
package udma_pkg;

    localparam int unsigned TIME_W = 5;
    localparam int unsigned BSEL_W = 2;

    typedef struct packed {
        logic [BSEL_W-1:0] base_sel;
        logic [TIME_W-1:0] rp;
        logic [TIME_W-1:0] ct;
    } drive_timing_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } burst_state_t;

    function automatic logic [TIME_W-1:0] at_least_one(input logic [TIME_W-1:0] v);
        return (v == '0) ? TIME_W'(1) : v;
    endfunction

endpackage

// File: rtl/udma_timing_regs.sv
module udma_timing_regs
    import udma_pkg::*;
#(
    parameter int unsigned N_DRIVES = 4,
    parameter int unsigned DRV_W    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DRV_W-1:0]  wr_drive,
    input  drive_timing_t     wr_word,
    input  logic [DRV_W-1:0]  rd_drive,
    output drive_timing_t     rd_word
);

    drive_timing_t slot [N_DRIVES];

    for (genvar g = 0; g < N_DRIVES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot[g] <= '0;
            end else if (wr_en && (wr_drive == DRV_W'(g))) begin
                slot[g] <= wr_word;
            end
        end
    end

    drive_timing_t raw;

    always_comb begin
        raw = '0;
        for (int i = 0; i < N_DRIVES; i++) begin
            if (rd_drive == DRV_W'(i)) raw = slot[i];
        end
        rd_word          = raw;
        rd_word.ct       = at_least_one(raw.ct);
        rd_word.rp       = at_least_one(raw.rp);
    end

endmodule

// File: rtl/udma_tick_counter.sv
module udma_tick_counter #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         en,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         ready
);

    logic [W-1:0] cnt;
    logic         inc;
    logic [W:0]   sum;

    assign inc   = en & tick;
    assign sum   = {1'b0, cnt} + {{W{1'b0}}, inc};
    assign ready = (sum >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (inc && (cnt < limit)) begin
            cnt <= cnt + 1'b1;
        end
    end

    p_count_bounded_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt <= limit));

endmodule

// File: rtl/udma_read_capture.sv
module udma_read_capture #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              dev_strobe,
    input  logic [DATA_W-1:0] dev_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    logic strb_q;
    logic edge_seen;

    assign edge_seen = dev_strobe ^ strb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strb_q   <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            strb_q   <= dev_strobe;
            rd_valid <= en && edge_seen;
            if (en && edge_seen) rd_data <= dev_data;
        end
    end

    p_capture_in_read_r8: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(en));

endmodule

// File: rtl/udma_strobe_timer.sv
module udma_strobe_timer
    import udma_pkg::*;
#(
    parameter int unsigned N_DRIVES = 4,
    parameter int unsigned N_BASE   = 2,
    parameter int unsigned DATA_W   = 16,
    localparam int unsigned DRV_W   = (N_DRIVES > 1) ? $clog2(N_DRIVES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [DRV_W-1:0]  cfg_drive,
    input  logic [TIME_W-1:0] cfg_ct,
    input  logic [TIME_W-1:0] cfg_rp,
    input  logic [BSEL_W-1:0] cfg_base,
    input  logic [N_BASE-1:0] base_tick,
    input  logic              start,
    input  logic [DRV_W-1:0]  start_drive,
    input  logic              start_read,
    input  logic              end_req,
    input  logic              peer_rdy,
    input  logic              fifo_valid,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              fifo_pop,
    output logic              host_strobe,
    output logic [DATA_W-1:0] host_data,
    output logic              stop,
    input  logic              dev_strobe,
    input  logic [DATA_W-1:0] dev_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    localparam int unsigned NSEL = 2 ** BSEL_W;

    burst_state_t  state;
    drive_timing_t lat;
    drive_timing_t sel_word;
    drive_timing_t cfg_word;
    logic          term_q;
    logic          paused_q;
    logic          start_acc;
    logic          wr_ready;
    logic          rp_ready;
    logic          wr_edge;
    logic          wr_finish;
    logic          rd_finish;
    logic          pause_en;
    logic          sel_tick;
    logic [NSEL-1:0] tick_pad;

    assign cfg_word = '{base_sel: cfg_base, rp: cfg_rp, ct: cfg_ct};

    udma_timing_regs #(
        .N_DRIVES (N_DRIVES),
        .DRV_W    (DRV_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_we),
        .wr_drive (cfg_drive),
        .wr_word  (cfg_word),
        .rd_drive (start_drive),
        .rd_word  (sel_word)
    );

    for (genvar gi = 0; gi < NSEL; gi++) begin : g_tick
        if (gi < N_BASE) begin : g_real
            assign tick_pad[gi] = base_tick[gi];
        end else begin : g_none
            assign tick_pad[gi] = 1'b0;
        end
    end

    assign sel_tick  = tick_pad[lat.base_sel];
    assign start_acc = start && (state == ST_IDLE);
    assign wr_edge   = (state == ST_WRITE) && !term_q && wr_ready && fifo_valid;
    assign wr_finish = (state == ST_WRITE) && term_q && wr_ready;
    assign pause_en  = (state == ST_READ) && (paused_q || (term_q && !peer_rdy));
    assign rd_finish = pause_en && rp_ready;
    assign fifo_pop  = wr_edge;

    udma_tick_counter #(.W(TIME_W)) u_cycle_ctr (
        .clk   (clk),
        .rst   (rst),
        .clear (start_acc || wr_edge),
        .en    (state == ST_WRITE),
        .tick  (sel_tick),
        .limit (lat.ct),
        .ready (wr_ready)
    );

    udma_tick_counter #(.W(TIME_W)) u_pause_ctr (
        .clk   (clk),
        .rst   (rst),
        .clear (start_acc),
        .en    (pause_en),
        .tick  (sel_tick),
        .limit (lat.rp),
        .ready (rp_ready)
    );

    udma_read_capture #(.DATA_W(DATA_W)) u_capture (
        .clk        (clk),
        .rst        (rst),
        .en         (state == ST_READ),
        .dev_strobe (dev_strobe),
        .dev_data   (dev_data),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            lat         <= '0;
            term_q      <= 1'b0;
            paused_q    <= 1'b0;
            stop        <= 1'b0;
            host_strobe <= 1'b0;
            host_data   <= '0;
        end else if (start_acc) begin
            state    <= start_read ? ST_READ : ST_WRITE;
            lat      <= sel_word;
            term_q   <= 1'b0;
            paused_q <= 1'b0;
            stop     <= 1'b0;
        end else begin
            if (end_req && (state != ST_IDLE)) term_q <= 1'b1;
            if (pause_en) paused_q <= 1'b1;
            if (wr_edge) begin
                host_strobe <= ~host_strobe;
                host_data   <= fifo_data;
            end
            if (wr_finish || rd_finish) begin
                stop  <= 1'b1;
                state <= ST_IDLE;
            end
        end
    end

    p_pop_moves_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |=> (host_strobe != $past(host_strobe)));

    p_stop_freezes_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        stop |=> $stable(host_strobe));

    p_snapshot_held_r7: assert property (@(posedge clk) disable iff (rst)
        ((state != ST_IDLE) && ($past(state) != ST_IDLE)) |-> $stable(lat));

    p_no_pop_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !fifo_pop);

endmodule

// File: tb/udma_strobe_timer_bench.sv
module udma_strobe_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          cfg_we = 0;
    logic [1:0]    cfg_drive = 0;
    logic [4:0]    cfg_ct = 0, cfg_rp = 0;
    logic [1:0]    cfg_base = 0;
    logic [1:0]    base_tick = 0;
    logic          start = 0, start_read = 0, end_req = 0, peer_rdy = 1;
    logic [1:0]    start_drive = 0;
    logic          fifo_valid = 0;
    logic [DW-1:0] fifo_data = 0;
    logic          fifo_pop, host_strobe, stop, rd_valid;
    logic [DW-1:0] host_data, rd_data;
    logic          dev_strobe = 0;
    logic [DW-1:0] dev_data = 0;

    udma_strobe_timer u_udma_strobe_timer (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_drive(cfg_drive),
        .cfg_ct(cfg_ct), .cfg_rp(cfg_rp), .cfg_base(cfg_base),
        .base_tick(base_tick), .start(start), .start_drive(start_drive),
        .start_read(start_read), .end_req(end_req), .peer_rdy(peer_rdy),
        .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
        .host_strobe(host_strobe), .host_data(host_data), .stop(stop),
        .dev_strobe(dev_strobe), .dev_data(dev_data),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Bench model of the timing registers
    int m_ct [4], m_rp [4], m_sel [4];
    int cur_ct = 1, cur_rp = 1, cur_sel = 0;
    string ct_tag = "R4", rp_tag = "R9";

    logic [DW-1:0] src_q [$];
    logic [DW-1:0] exp_q [$];
    logic [DW-1:0] rd_exp [$];
    bit  fifo_hold = 0, pop_pend = 0, rd_on = 0, pause_mon = 0;
    logic prev_strb = 0;
    int  acc = 0, acc_p = 0, cyc = 0;
    bit  stall = 0;

    // Drivers of the FIFO and the base ticks, just after the rising edge
    always @(posedge clk) begin
        #1;
        if (pop_pend) begin
            void'(src_q.pop_front());
            pop_pend = 0;
        end
        fifo_valid = (src_q.size() > 0) && !fifo_hold;
        fifo_data  = (src_q.size() > 0) ? src_q[0] : '0;
        cyc++;
        base_tick[0] = 1'b1;
        base_tick[1] = (cyc % 3 == 0);
    end

    // Monitor and scoreboard, at the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            if (host_strobe !== prev_strb) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R3", "strobe edge with no word", int'(host_data), -1);
                end else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    chk(host_data == e, "R3", "word on strobe edge", int'(host_data), int'(e));
                end
                if (stall) chk(acc >= cur_ct, "R6", "ticks across stall", acc, cur_ct);
                else       chk(acc == cur_ct, ct_tag, "ticks between edges", acc, cur_ct);
                acc = 0;
                stall = 0;
            end
            prev_strb = host_strobe;
            if (start) begin
                acc = 0;
                stall = 0;
            end else begin
                acc += int'(base_tick[cur_sel]);
                if (!fifo_valid) stall = 1;
            end
            if (fifo_pop) begin
                exp_q.push_back(fifo_data);
                pop_pend = 1;
            end
            if (rd_valid) begin
                if (rd_exp.size() == 0) begin
                    chk(0, "R8", "unexpected read word", int'(rd_data), -1);
                end else begin
                    logic [DW-1:0] e;
                    e = rd_exp.pop_front();
                    chk(rd_data == e, "R8", "captured read word", int'(rd_data), int'(e));
                end
            end
            if (pause_mon) begin
                if (stop) begin
                    chk(acc_p == cur_rp, rp_tag, "ticks before stop", acc_p, cur_rp);
                    pause_mon = 0;
                end else begin
                    acc_p += int'(base_tick[cur_sel]);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic cfg_write(input int d, input int ct, input int rp, input int sel);
        step(1);
        m_ct[d] = ct; m_rp[d] = rp; m_sel[d] = sel;
        cfg_we = 1; cfg_drive = 2'(d); cfg_ct = 5'(ct); cfg_rp = 5'(rp); cfg_base = 2'(sel);
        step(1);
        cfg_we = 0;
    endtask

    task automatic burst(input int d, input bit rd);
        step(1);
        cur_ct  = (m_ct[d] == 0) ? 1 : m_ct[d];
        cur_rp  = (m_rp[d] == 0) ? 1 : m_rp[d];
        cur_sel = m_sel[d];
        start = 1; start_drive = 2'(d); start_read = rd;
        step(1);
        start = 0;
    endtask

    task automatic end_pulse();
        step(1);
        end_req = 1;
        step(1);
        end_req = 0;
    endtask

    task automatic load(input int n, input int base);
        for (int i = 0; i < n; i++) src_q.push_back(DW'(base + i * 37));
    endtask

    task automatic drain(input string req);
        int t = 0;
        while ((src_q.size() > 0 || exp_q.size() > 0) && t < 3000) begin
            step(1);
            t++;
        end
        chk(t < 3000, req, "all words sent", t, 0);
    endtask

    task automatic wait_stop(input string req);
        int t = 0;
        while (!stop && t < 500) begin
            step(1);
            t++;
        end
        chk(stop == 1'b1, req, "stop raised", int'(stop), 1);
    endtask

    task automatic read_edge(input logic [DW-1:0] d);
        step(1);
        dev_data = d;
        dev_strobe = ~dev_strobe;
        if (rd_on) rd_exp.push_back(d);
        step(1);
    endtask

    task automatic read_burst(input int d, input string tag);
        peer_rdy = 1;
        burst(d, 1);
        rd_on = 1;
        rp_tag = tag;
        for (int i = 0; i < 5; i++) read_edge(DW'(16'h1000 + d * 256 + i * 7));
        end_pulse();
        step(2);
        peer_rdy = 0;
        acc_p = 0;
        pause_mon = 1;
        wait_stop(tag);
        step(2);
        chk(pause_mon == 0, tag, "pause window checked", int'(pause_mon), 0);
        rd_on = 0;
        peer_rdy = 1;
        read_edge(DW'(16'hdead));
        read_edge(DW'(16'hbeef));
        step(3);
        chk(rd_exp.size() == 0, "R8", "read queue empty", rd_exp.size(), 0);
    endtask

    initial begin
        logic s;
        int   n;
        step(5);
        rst = 0;
        step(1);
        chk(host_strobe == 0, "R1", "strobe after reset", int'(host_strobe), 0);
        chk(stop == 0, "R1", "stop after reset", int'(stop), 0);
        chk(fifo_pop == 0, "R1", "pop after reset", int'(fifo_pop), 0);
        chk(rd_valid == 0, "R1", "read valid after reset", int'(rd_valid), 0);

        cfg_write(0, 3, 2, 0);
        cfg_write(1, 2, 4, 1);
        cfg_write(2, 0, 0, 0);

        // Write on drive 0 with a stall, a mid-burst reconfig and a termination
        load(20, 100);
        ct_tag = "R4";
        burst(0, 0);
        step(15);
        fifo_hold = 1;
        step(2);
        s = host_strobe;
        step(10);
        chk(host_strobe == s, "R6", "strobe held while empty", int'(host_strobe), int'(s));
        fifo_hold = 0;
        cfg_write(0, 6, 2, 0);
        ct_tag = "R7";
        step(12);
        end_pulse();
        wait_stop("R10");
        s = host_strobe;
        n = src_q.size();
        step(12);
        chk(host_strobe == s, "R10", "strobe frozen after stop", int'(host_strobe), int'(s));
        chk(src_q.size() == n, "R10", "no pops after stop", src_q.size(), n);
        chk(src_q.size() > 0, "R10", "words were still waiting", src_q.size(), 1);
        src_q.delete();
        step(2);

        // Drive 1: other cycle time on the slow base
        ct_tag = "R2";
        load(8, 2000);
        burst(1, 0);
        drain("R2");
        end_pulse();
        wait_stop("R10");

        // Drive 2: zero cycle time
        ct_tag = "R5";
        load(6, 3000);
        burst(2, 0);
        drain("R5");
        end_pulse();
        wait_stop("R10");

        read_burst(0, "R9");
        read_burst(2, "R5");
        read_burst(1, "R2");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule